// File: doc/BRIEF.md
# Marker-Based Multi-Lane Deskew Aligner

This block receives a bundle of parallel lanes that have crossed an interconnect with unequal delays. Each lane carries a data word and a one-bit marker flag. The sender raises the marker as a single-cycle pulse on every lane in the same cycle, and repeats it every 16 cycles. The block finds the cycle in which the marker reaches each lane, then adds delay stages to the early lanes so that every lane lines up with the lane whose marker arrives last. It can compensate up to three cycles of spread.

Evaluation starts on its own after reset, and again after a two-cycle clear pulse. The block reports which lanes have shown a marker, when evaluation has finished, whether it passed, and when the aligned data may be used. Once the aligned data is valid, a monitor watches the aligned markers. It latches an error if they ever split across cycles, or if their spacing moves away from the 16-cycle period. The error stays latched until a clear or an asynchronous reset.

Top module: `dsk_aligner`

## Requirements
- R1: After an asynchronous reset, `eval_done`, `eval_pass`, `algn_valid`, `mon_err` and `chan_seen` are 0. A new evaluation starts by itself on the first marker after reset is released.
- R2: The capture window opens in the first cycle c0 in which any lane shows a marker. It spans the four cycles c0 to c0+3, and a marker's offset is its cycle minus c0. `eval_done` is 1 from cycle c0+4 and stays 1 until a clear or a reset.
- R3: Each lane gets a delay of (latest offset in the window) minus (its own offset). The block registers `algn_data`/`algn_mark` lane i (data bits i*DW and up) so that they show that lane's input from 1+delay cycles earlier. As a result, every lane shows the sender word of the same launch cycle, and the aligned markers of all lanes rise in the same cycle.
- R4: `eval_pass` and `algn_valid` go to 1 together with `eval_done` only if every lane showed a marker inside the window. Otherwise both stay 0. A lane whose skew exceeds the earliest lane's by more than three cycles counts as missing.
- R5: Bit i of `chan_seen` becomes 1 in the cycle after a marker is present on lane i, and holds until a clear or a reset. A lane that never carries a marker leaves its bit at 0.
- R6: A cycle with `clr` at 1 clears `eval_done`, `eval_pass`, `algn_valid`, `mon_err` and `chan_seen` at the following edge, and markers seen during that cycle are ignored. Evaluation restarts on the first marker after `clr` returns to 0.
- R7: From the fifth cycle of `algn_valid` onward, a cycle in which some but not all aligned markers are 1 sets `mon_err`.
- R8: Once the monitor has seen one aligned marker, it sets `mon_err` in either of two cases: an aligned marker arrives other than 16 cycles after the previous one, or no marker arrives 16 cycles after it.
- R9: `mon_err` stays 1 until a `clr` cycle or an asynchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Restart evaluation and clear status (held two cycles) |
| lane_data | input | LANES*DW | Skewed data words, lane i at bits i*DW |
| lane_mark | input | LANES | Skewed marker flag per lane |
| algn_data | output | LANES*DW | Aligned data words |
| algn_mark | output | LANES | Aligned marker flags |
| chan_seen | output | LANES | Per-lane marker-seen flags |
| eval_done | output | 1 | Evaluation finished |
| eval_pass | output | 1 | Evaluation result: 1 when all lanes fit the window |
| algn_valid | output | 1 | Aligned data usable |
| mon_err | output | 1 | Latched monitor error |

## Verification
The bench first applies uneven lane skews and confirms that all lanes come out carrying the same launch cycle. A design that picked the earliest lane as its reference, or that dropped a stage, would show words from different cycles. It then moves one lane by a cycle after alignment, and later shifts the marker phase on all lanes. Together these separate the split-marker check from the period check: a monitor missing either one would leave `mon_err` at 0. A lane with no markers at all and a lane skewed by four cycles must both give a failed evaluation with `algn_valid` low. An off-by-one window would accept the four-cycle lane. Finally, clear and asynchronous reset must each drop a latched error and lead to a fresh evaluation.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

   typedef enum logic [1:0] {
      EV_IDLE = 2'd0,
      EV_CAPT = 2'd1,
      EV_DONE = 2'd2
   } ev_state_t;

endpackage

// File: rtl/dsk_lane_delay.sv
module dsk_lane_delay #(
   parameter int DW       = 8,
   parameter int MAX_SKEW = 3,
   parameter int SEL_W    = $clog2(MAX_SKEW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    in_data,
   input  logic             in_mark,
   input  logic [SEL_W-1:0] sel,
   output logic [DW-1:0]    out_data,
   output logic             out_mark
);
   localparam int WW = DW + 1;

   logic [WW-1:0] stage [MAX_SKEW];
   logic [WW-1:0] tap;

   // delay line: stage k holds the input of k+1 cycles ago
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < MAX_SKEW; k++) stage[k] <= '0;
      end else begin
         stage[0] <= {in_mark, in_data};
         for (int k = 1; k < MAX_SKEW; k++) stage[k] <= stage[k-1];
      end
   end

   always_comb begin
      tap = {in_mark, in_data};
      for (int k = 0; k < MAX_SKEW; k++) begin
         if (int'(sel) == k + 1) tap = stage[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) {out_mark, out_data} <= '0;
      else        {out_mark, out_data} <= tap;
   end

   // R3: a lane with zero added delay passes through exactly one register
   a_r3_zero_delay_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |=> ({out_mark, out_data} == $past({in_mark, in_data})));

endmodule

// File: rtl/dsk_eval.sv
module dsk_eval
   import dsk_pkg::*;
#(
   parameter int LANES    = 8,
   parameter int MAX_SKEW = 3,
   parameter int SEL_W    = $clog2(MAX_SKEW + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic [LANES-1:0]            mark,
   output logic [LANES-1:0]            seen_any,
   output logic                        done,
   output logic                        pass,
   output logic                        valid,
   output logic [LANES-1:0][SEL_W-1:0] sel
);
   localparam logic [SEL_W-1:0] LAST_OFS = SEL_W'(MAX_SKEW);

   ev_state_t                   st;
   logic [SEL_W-1:0]            ofs;
   logic [LANES-1:0]            win_seen;
   logic [LANES-1:0][SEL_W-1:0] arr;
   logic [SEL_W-1:0]            latest;
   logic [LANES-1:0]            seen_nxt;

   assign seen_nxt = win_seen | mark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= EV_IDLE;
         ofs      <= '0;
         win_seen <= '0;
         arr      <= '0;
         seen_any <= '0;
         done     <= 1'b0;
         pass     <= 1'b0;
         valid    <= 1'b0;
      end else if (clr) begin
         st       <= EV_IDLE;
         ofs      <= '0;
         win_seen <= '0;
         arr      <= '0;
         seen_any <= '0;
         done     <= 1'b0;
         pass     <= 1'b0;
         valid    <= 1'b0;
      end else begin
         seen_any <= seen_any | mark;
         unique case (st)
            EV_IDLE: begin
               if (|mark) begin
                  win_seen <= mark;
                  arr      <= '0;
                  ofs      <= SEL_W'(1);
                  st       <= EV_CAPT;
               end
            end
            EV_CAPT: begin
               for (int i = 0; i < LANES; i++) begin
                  if (mark[i] && !win_seen[i]) arr[i] <= ofs;
               end
               win_seen <= seen_nxt;
               if (ofs == LAST_OFS) begin
                  st    <= EV_DONE;
                  done  <= 1'b1;
                  pass  <= &seen_nxt;
                  valid <= &seen_nxt;
               end else begin
                  ofs <= ofs + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      latest = '0;
      for (int i = 0; i < LANES; i++) begin
         if (win_seen[i] && arr[i] > latest) latest = arr[i];
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_sel
      assign sel[g] = win_seen[g] ? SEL_W'(latest - arr[g]) : '0;
   end

   // R4: usable data implies a finished, passing evaluation
   a_r4_valid_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (done && pass));
   // R2: completion is held until clear
   a_r2_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done);
   // R6: a clear cycle empties every status flag
   a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!done && !pass && !valid && seen_any == '0));
   // R5: seen flags only accumulate outside clear
   a_r5_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((seen_any & $past(seen_any)) == $past(seen_any)));

endmodule

// File: rtl/dsk_monitor.sv
module dsk_monitor #(
   parameter int LANES    = 8,
   parameter int MAX_SKEW = 3,
   parameter int PERIOD   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             valid,
   input  logic [LANES-1:0] amark,
   output logic             err
);
   localparam int SETTLE = MAX_SKEW + 1;
   localparam int ST_W   = $clog2(SETTLE + 1);
   localparam int PH_W   = $clog2(PERIOD);
   localparam logic [ST_W-1:0] SETTLE_V = ST_W'(SETTLE);
   localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD - 1);

   logic [ST_W-1:0] settle;
   logic [PH_W-1:0] ph;
   logic            primed;
   logic            armed;
   logic            any_m;
   logic            all_m;

   assign armed = valid && (settle == SETTLE_V);
   assign any_m = |amark;
   assign all_m = &amark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle <= '0;
         ph     <= '0;
         primed <= 1'b0;
         err    <= 1'b0;
      end else if (clr) begin
         settle <= '0;
         ph     <= '0;
         primed <= 1'b0;
         err    <= 1'b0;
      end else if (!valid) begin
         settle <= '0;
         ph     <= '0;
         primed <= 1'b0;
      end else if (!armed) begin
         settle <= settle + 1'b1;
      end else begin
         if (any_m && !all_m) err <= 1'b1;
         if (primed && (any_m != (ph == PH_LAST))) err <= 1'b1;
         if (any_m) begin
            primed <= 1'b1;
            ph     <= '0;
         end else if (ph != PH_LAST) begin
            ph <= ph + 1'b1;
         end
      end
   end

   // R9: a latched error survives until clear
   a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   // R7: split aligned markers are caught
   a_r7_split_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !clr && any_m && !all_m) |=> err);
   // R8: an early marker is caught
   a_r8_early_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !clr && primed && any_m && ph != PH_LAST) |=> err);

endmodule

// File: rtl/dsk_aligner.sv
module dsk_aligner #(
   parameter int LANES    = 8,
   parameter int DW       = 8,
   parameter int MAX_SKEW = 3,
   parameter int PERIOD   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic [LANES*DW-1:0]   lane_data,
   input  logic [LANES-1:0]      lane_mark,
   output logic [LANES*DW-1:0]   algn_data,
   output logic [LANES-1:0]      algn_mark,
   output logic [LANES-1:0]      chan_seen,
   output logic                  eval_done,
   output logic                  eval_pass,
   output logic                  algn_valid,
   output logic                  mon_err
);
   localparam int SEL_W = $clog2(MAX_SKEW + 1);

   if (LANES < 2) begin : g_bad_lanes
      $error("dsk_aligner: LANES must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dsk_aligner: DW must be at least 1");
   end
   if (MAX_SKEW < 1) begin : g_bad_skew
      $error("dsk_aligner: MAX_SKEW must be at least 1");
   end
   if (PERIOD <= 2 * (MAX_SKEW + 1)) begin : g_bad_period
      $error("dsk_aligner: PERIOD too short for the skew window");
   end

   logic [LANES-1:0][SEL_W-1:0] sel;

   dsk_eval #(
      .LANES(LANES), .MAX_SKEW(MAX_SKEW), .SEL_W(SEL_W)
   ) u_eval (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mark(lane_mark),
      .seen_any(chan_seen), .done(eval_done), .pass(eval_pass),
      .valid(algn_valid), .sel(sel)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dsk_lane_delay #(
         .DW(DW), .MAX_SKEW(MAX_SKEW), .SEL_W(SEL_W)
      ) u_dly (
         .clk(clk), .rst_n(rst_n),
         .in_data(lane_data[g*DW +: DW]), .in_mark(lane_mark[g]),
         .sel(sel[g]),
         .out_data(algn_data[g*DW +: DW]), .out_mark(algn_mark[g])
      );
   end

   dsk_monitor #(
      .LANES(LANES), .MAX_SKEW(MAX_SKEW), .PERIOD(PERIOD)
   ) u_mon (
      .clk(clk), .rst_n(rst_n), .clr(clr), .valid(algn_valid),
      .amark(algn_mark), .err(mon_err)
   );

   // R1: nothing is flagged in the cycle after a reset release without markers
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && !$past(clr)) |-> (!eval_done && !mon_err));

endmodule

// File: tb/sim_dsk_aligner.sv
module sim_dsk_aligner;
   localparam int LANES      = 8;
   localparam int DW         = 8;
   localparam int MAX_SKEW   = 3;
   localparam int PERIOD     = 16;
   localparam int CLK_PERIOD = 10;
   localparam int HIST       = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic [LANES*DW-1:0] lane_data = '0;
   logic [LANES-1:0]    lane_mark = '0;
   logic [LANES*DW-1:0] algn_data;
   logic [LANES-1:0]    algn_mark;
   logic [LANES-1:0]    chan_seen;
   logic eval_done, eval_pass, algn_valid, mon_err;

   dsk_aligner #(.LANES(LANES), .DW(DW), .MAX_SKEW(MAX_SKEW), .PERIOD(PERIOD)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lane_data(lane_data), .lane_mark(lane_mark),
      .algn_data(algn_data), .algn_mark(algn_mark), .chan_seen(chan_seen),
      .eval_done(eval_done), .eval_pass(eval_pass), .algn_valid(algn_valid), .mon_err(mon_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit started = 1'b0;

   int skew [LANES];
   int phase = 5;
   logic [LANES-1:0] kill = '0;
   int cyc = 0;

   logic [LANES-1:0]    h_mark [HIST];
   logic [LANES*DW-1:0] h_data [HIST];

   // reference model state
   int m_st, m_k, m_settle, m_ph, m_vcnt;
   int m_arr [LANES];
   int m_d [LANES];
   logic [LANES-1:0] m_seen, m_active, om_t;
   bit m_done, m_pass, m_valid, m_err, m_primed;

   function automatic logic [DW-1:0] word(int x, int i);
      return DW'(x * 37 + i * 11 + 5);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // sender plus per-lane skew
   always @(negedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         int x;
         x = cyc - skew[i];
         lane_mark[i] <= (x >= 0) && !kill[i] && ((((x - phase) % PERIOD) + PERIOD) % PERIOD == 0);
         lane_data[i*DW +: DW] <= word(x, i);
      end
   end

   task automatic m_clear_all();
      m_st = 0; m_k = 0; m_seen = '0; m_active = '0;
      m_done = 0; m_pass = 0; m_valid = 0;
      for (int i = 0; i < LANES; i++) begin m_arr[i] = 0; m_d[i] = 0; end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_clear_all();
         m_err = 0; m_settle = 0; m_primed = 0; m_ph = 0; m_vcnt = 0;
      end else begin
         h_mark[cyc % HIST] = lane_mark;
         h_data[cyc % HIST] = lane_data;
         om_t = '0;
         if (m_valid) begin
            for (int i = 0; i < LANES; i++) begin
               int c2;
               c2 = cyc - 1 - m_d[i];
               if (c2 >= 0) om_t[i] = h_mark[c2 % HIST][i];
            end
         end
         // monitor (uses valid as it was during this cycle)
         if (clr) begin
            m_err = 0; m_settle = 0; m_primed = 0; m_ph = 0;
         end else if (!m_valid) begin
            m_settle = 0; m_primed = 0; m_ph = 0;
         end else if (m_settle < MAX_SKEW + 1) begin
            m_settle++;
         end else begin
            if ((|om_t) && !(&om_t)) m_err = 1;
            if (m_primed && ((|om_t) != (m_ph == PERIOD - 1))) m_err = 1;
            if (|om_t) begin m_primed = 1; m_ph = 0; end
            else if (m_ph < PERIOD - 1) m_ph++;
         end
         // evaluation
         if (clr) begin
            m_clear_all();
         end else begin
            m_active = m_active | lane_mark;
            if (m_st == 0) begin
               if (|lane_mark) begin
                  m_seen = lane_mark;
                  for (int i = 0; i < LANES; i++) m_arr[i] = 0;
                  m_k = 1; m_st = 1;
               end
            end else if (m_st == 1) begin
               for (int i = 0; i < LANES; i++)
                  if (lane_mark[i] && !m_seen[i]) m_arr[i] = m_k;
               m_seen = m_seen | lane_mark;
               if (m_k == MAX_SKEW) begin
                  int lat;
                  lat = 0;
                  for (int i = 0; i < LANES; i++) if (m_seen[i] && m_arr[i] > lat) lat = m_arr[i];
                  for (int i = 0; i < LANES; i++) m_d[i] = m_seen[i] ? lat - m_arr[i] : 0;
                  m_st = 2; m_done = 1; m_pass = &m_seen; m_valid = m_pass;
               end else begin
                  m_k++;
               end
            end
         end
         m_vcnt = m_valid ? m_vcnt + 1 : 0;
         cyc++;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (started) begin
         check(eval_done == m_done, "R2 eval_done", 64'(eval_done), 64'(m_done));
         check(eval_pass == m_pass, "R4 eval_pass", 64'(eval_pass), 64'(m_pass));
         check(algn_valid == m_valid, "R4 algn_valid", 64'(algn_valid), 64'(m_valid));
         check(chan_seen == m_active, "R5 chan_seen", 64'(chan_seen), 64'(m_active));
         check(mon_err == m_err, "R9 mon_err", 64'(mon_err), 64'(m_err));
         if (m_valid && m_vcnt >= 2) begin
            for (int i = 0; i < LANES; i++) begin
               int c2;
               c2 = cyc - 1 - m_d[i];
               check(algn_data[i*DW +: DW] == h_data[c2 % HIST][i*DW +: DW], "R3 algn_data",
                     64'(algn_data[i*DW +: DW]), 64'(h_data[c2 % HIST][i*DW +: DW]));
               check(algn_mark[i] == h_mark[c2 % HIST][i], "R3 algn_mark",
                     64'(algn_mark[i]), 64'(h_mark[c2 % HIST][i]));
            end
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic clear_pulse();
      clr = 1'b1;
      step(2);
      clr = 1'b0;
   endtask

   // R3: all lanes carry the word launched max-skew+1 cycles before
   task automatic check_aligned();
      int maxs;
      maxs = 0;
      for (int i = 0; i < LANES; i++) if (skew[i] > maxs) maxs = skew[i];
      for (int n = 0; n < 40; n++) begin
         step(1);
         if (algn_valid && (|algn_mark)) begin
            check(&algn_mark, "R3 markers together", 64'(algn_mark), 64'({LANES{1'b1}}));
            for (int i = 0; i < LANES; i++)
               check(algn_data[i*DW +: DW] == word(cyc - 1 - maxs, i), "R3 common launch word",
                     64'(algn_data[i*DW +: DW]), 64'(word(cyc - 1 - maxs, i)));
            return;
         end
      end
      check(1'b0, "R3 no aligned marker", 64'(algn_mark), 64'(1));
   endtask

   initial begin
      int sk0 [LANES] = '{0, 1, 2, 3, 1, 0, 2, 3};
      for (int i = 0; i < LANES; i++) skew[i] = sk0[i];
      step(3);
      rst_n = 1'b1;
      started = 1'b1;
      // R1: quiet after reset
      check(!eval_done && !eval_pass && !algn_valid && !mon_err && chan_seen == '0, "R1 reset state",
            64'({eval_done, eval_pass, algn_valid, mon_err, chan_seen}), 64'(0));
      step(60);
      check(eval_done, "R2 done after window", 64'(eval_done), 64'(1));
      check(eval_pass && algn_valid, "R4 pass with all lanes", 64'({eval_pass, algn_valid}), 64'(3));
      check(chan_seen == '1, "R5 all lanes seen", 64'(chan_seen), 64'(8'hFF));
      check_aligned();
      step(40);
      check(!mon_err, "R8 steady period no error", 64'(mon_err), 64'(0));

      // R7: one lane slips after alignment
      skew[2] = 3;
      step(40);
      check(mon_err, "R7 split markers latch", 64'(mon_err), 64'(1));
      step(30);
      check(mon_err, "R9 error held", 64'(mon_err), 64'(1));

      // R6: clear
      clr = 1'b1;
      step(2);
      check(!eval_done && !eval_pass && !algn_valid && !mon_err && chan_seen == '0, "R6 clear empties",
            64'({eval_done, eval_pass, algn_valid, mon_err, chan_seen}), 64'(0));
      clr = 1'b0;
      step(60);
      check(algn_valid && !mon_err, "R6 re-evaluation passes", 64'({algn_valid, mon_err}), 64'(2));
      check_aligned();

      // R8: marker phase moves on all lanes
      phase = phase + 5;
      step(40);
      check(mon_err, "R8 period change latches", 64'(mon_err), 64'(1));

      // R4/R5: lane without markers
      kill[5] = 1'b1;
      clear_pulse();
      step(60);
      check(eval_done && !eval_pass && !algn_valid, "R4 missing lane fails",
            64'({eval_done, eval_pass, algn_valid}), 64'(4));
      check(chan_seen == 8'hDF, "R5 silent lane not seen", 64'(chan_seen), 64'(8'hDF));

      // R4: four-cycle spread
      kill = '0;
      for (int i = 0; i < LANES; i++) skew[i] = 1;
      skew[0] = 0;
      skew[1] = 4;
      clear_pulse();
      step(60);
      check(eval_done && !eval_pass && !algn_valid, "R4 spread beyond window fails",
            64'({eval_done, eval_pass, algn_valid}), 64'(4));

      // R9: asynchronous reset drops a latched error, R1 restart
      for (int i = 0; i < LANES; i++) skew[i] = sk0[i];
      clear_pulse();
      step(60);
      check(algn_valid, "R4 valid before reset test", 64'(algn_valid), 64'(1));
      skew[0] = 1;
      step(40);
      check(mon_err, "R7 slip before reset", 64'(mon_err), 64'(1));
      rst_n = 1'b0;
      #1;
      check(!mon_err && !eval_done && !algn_valid, "R9 async reset clears",
            64'({mon_err, eval_done, algn_valid}), 64'(0));
      step(2);
      rst_n = 1'b1;
      step(60);
      check(eval_done && algn_valid && !mon_err, "R1 restart after reset",
            64'({eval_done, algn_valid, mon_err}), 64'(6));
      check_aligned();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule